// File: doc/BRIEF.md
# Asynchronous Frame Serializer with Hardware Parity

This block turns one word per accepted request into an asynchronous serial frame on a single output line. A frame opens with a low start bit, carries eight or nine data bits least significant first, and closes with a high stop bit. Every bit lasts a fixed number of pulses of a baud enable that comes from outside. In nine-bit mode the top data bit comes from a separate input next to the data byte. Parity can be produced in hardware. When it is, the parity value replaces the top data bit of the frame, so the frame length stays the same.

Words enter over a valid/ready handshake. A word is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when no frame is in flight and the sleep control is low. A producer that finds `in_ready` low must hold `in_valid` and `in_data`/`in_bit9` steady until the transfer happens. Word length, parity enable and parity polarity are copied at the transfer, so the frame in flight never sees later changes to them. Raising the sleep control lets the current frame run to its stop bit. After that the line stays high, the bit-time counter stays still, and no new word is accepted until sleep is released.

Top module: `sftx_top`

## Requirements
- R1: After reset `tx_line` is 1, `busy` is 0, `done` is 0 and `in_ready` is 1 (with `cfg_sleep` low).
- R2: A transfer happens on an edge where `in_valid` and `in_ready` are both 1. From the next cycle `busy` is 1, `in_ready` is 0 and `tx_line` is 0 (start bit).
- R3: With `cfg_nine`=0 and parity off, the frame is start 0, `in_data[0]`..`in_data[7]` in that order, then stop 1. Each bit lasts 16 `baud_tick` pulses.
- R4: With `cfg_nine`=1 the frame carries 9 data bits, and the ninth one (sent after `in_data[7]`) is `in_bit9`.
- R5: With `cfg_par_en`=1 the last data position (bit 7 in 8-bit mode, bit 8 in 9-bit mode) carries parity computed over the data bits before it. `cfg_par_odd`=0 makes the number of ones across all data positions even, and 1 makes it odd. In 9-bit mode with parity on, `in_bit9` is ignored.
- R6: Word length, parity enable and parity polarity are taken at the transfer. Changing parity enable or polarity during a frame has no effect on that frame.
- R7: `done` is a single-cycle pulse raised when the stop bit's last tick completes. `busy` falls in that same cycle.
- R8: Raising `cfg_sleep` during a frame lets it finish unchanged. While `cfg_sleep` is 1 and no frame is in flight, `in_ready` is 0, `busy` stays 0 and `tx_line` stays 1, even with `in_valid` high.
- R9: The line changes only at a transfer or after a `baud_tick`. While `baud_tick` stays low, a frame in flight holds its line level and `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling enable, 16 per bit |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken this cycle |
| in_data | input | 8 | Data byte |
| in_bit9 | input | 1 | Ninth data bit for 9-bit frames |
| cfg_nine | input | 1 | 0: 8 data bits, 1: 9 data bits |
| cfg_par_en | input | 1 | Hardware parity on |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_sleep | input | 1 | Stop at the next frame boundary |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume that the producer never changes `cfg_nine` while `busy` is high, that `baud_tick` is a synchronous level enable sampled on the clock, and that reset is held for at least one edge. The bench changes the word length only after it has seen `busy` low. It pulses `baud_tick` on every other clock and stops it for a long stretch once to test R9. It changes parity controls and sleep during frames only, where R6 and R8 say those changes must have no effect on the frame in flight.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } sftx_state_e;
endpackage

// File: rtl/sftx_prescaler.sv
module sftx_prescaler #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_end = run && tick && (cnt_q == LAST);

  // R9: without a tick the bit-time counter holds its value
  a_r9_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));
  // R8: an idle (sleeping or empty) block keeps the counter at zero
  a_r8_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/sftx_framer.sv
module sftx_framer #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic          bit9,
  input  logic          nine,
  input  logic          par_en,
  input  logic          par_odd,
  output logic [DW:0]   word
);
  localparam int WW = DW + 1;

  logic [WW-1:0] raw;
  logic [WW-1:0] below_mask;
  logic          par_bit;

  always_comb begin
    raw = {nine ? bit9 : 1'b0, data};
    below_mask = '0;
    for (int i = 0; i < WW; i++) begin
      below_mask[i] = nine ? (i < WW - 1) : (i < WW - 2);
    end
    par_bit = par_odd ^ (^(raw & below_mask));
    word = raw;
    if (par_en) begin
      if (nine) word[WW-1] = par_bit;
      else      word[WW-2] = par_bit;
    end
  end
endmodule

// File: rtl/sftx_sequencer.sv
module sftx_sequencer
  import sftx_pkg::*;
#(
  parameter int WW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] word,
  input  logic          nine,
  input  logic          bit_end,
  output logic          line,
  output logic          busy,
  output logic          done
);
  localparam int IW = $clog2(WW);
  localparam logic [IW-1:0] LAST9 = IW'(WW - 1);
  localparam logic [IW-1:0] LAST8 = IW'(WW - 2);

  sftx_state_e   state_q;
  logic [WW-1:0] shreg_q;
  logic [IW-1:0] idx_q;
  logic          nine_q;
  logic          done_q;
  logic [IW-1:0] last_idx;

  assign last_idx = nine_q ? LAST9 : LAST8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      nine_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (load) begin
            state_q <= ST_START;
            shreg_q <= word;
            nine_q  <= nine;
            idx_q   <= '0;
          end
        end
        ST_START: begin
          if (bit_end) state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (bit_end) begin
            shreg_q <= shreg_q >> 1;
            if (idx_q == last_idx) state_q <= ST_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg_q[0];
      default:  line = 1'b1;
    endcase
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  // R2: an accepted word opens with the start bit on the next cycle
  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> (busy && !line));
  // R7: done coincides with the end of busy
  a_r7_done_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R7: done never lasts two cycles
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: an idle line is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);
  // R4: the bit index stays within the selected word length
  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (idx_q <= last_idx));
endmodule

// File: rtl/sftx_top.sv
module sftx_top #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_bit9,
  input  logic          cfg_nine,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_sleep,
  output logic          tx_line,
  output logic          busy,
  output logic          done
);
  localparam int WW = DW + 1;

  logic          accept;
  logic [WW-1:0] framed;
  logic          bit_end;

  assign in_ready = !busy && !cfg_sleep;
  assign accept   = in_valid && in_ready;

  sftx_framer #(.DW(DW)) u_framer (
    .data    (in_data),
    .bit9    (in_bit9),
    .nine    (cfg_nine),
    .par_en  (cfg_par_en),
    .par_odd (cfg_par_odd),
    .word    (framed)
  );

  sftx_prescaler #(.OVS(OVS)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .tick    (baud_tick),
    .bit_end (bit_end)
  );

  sftx_sequencer #(.WW(WW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .word    (framed),
    .nine    (cfg_nine),
    .bit_end (bit_end),
    .line    (tx_line),
    .busy    (busy),
    .done    (done)
  );

  // R8: a sleeping idle block does not start a frame
  a_r8_sleep_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sleep && !busy) |=> !busy);
  // R9: line moves only at a transfer or after a baud tick
  a_r9_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_line) |-> ($past(baud_tick) || $past(accept)));
endmodule

// File: tb/tb_sftx_top.sv
module tb_sftx_top;
  typedef struct {
    logic [8:0] bits;
    int         n;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       tick_en = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_bit9 = 1'b0;
  logic       cfg_nine = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_sleep = 1'b0;
  logic       tx_line;
  logic       busy;
  logic       done;

  int   total = 0;
  int   fails = 0;
  int   sent = 0;
  int   frames_seen = 0;
  exp_t exp_q[$];

  sftx_top dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_bit9(in_bit9), .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_sleep(cfg_sleep),
    .tx_line(tx_line), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      baud_tick <= tick_en ? ~baud_tick : 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [8:0] build(input logic [7:0] d, input logic b9,
                                       input logic nine, input logic pe, input logic odd);
    logic [8:0] w;
    w = {nine ? b9 : 1'b0, d};
    if (pe) begin
      if (nine) w[8] = odd ^ (^w[7:0]);
      else      w[7] = odd ^ (^w[6:0]);
    end
    return w;
  endfunction

  task automatic send(input logic [7:0] d, input logic b9, input logic nine,
                      input logic pe, input logic odd, input string tag);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    cfg_nine = nine; cfg_par_en = pe; cfg_par_odd = odd;
    in_data = d; in_bit9 = b9; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    e.bits = build(d, b9, nine, pe, odd);
    e.n = nine ? 9 : 8;
    e.tag = tag;
    exp_q.push_back(e);
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
    check(busy && !tx_line && !in_ready, "R2 accept/start",
          {busy, tx_line, in_ready}, 3'b100);
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (baud_tick) c++;
    end
  endtask

  // monitor: pops expected frames and compares the serial line
  initial begin
    forever begin
      exp_t e;
      logic [8:0] got;
      bit seen;
      @(negedge clk);
      if (rst_n && !tx_line) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected frame", 1, 0);
          e.bits = '0; e.n = 8; e.tag = "R3";
        end else begin
          e = exp_q.pop_front();
        end
        wait_ticks(8);
        @(negedge clk);
        check(tx_line == 1'b0, {e.tag, " start bit"}, tx_line, 0);
        got = '0;
        for (int i = 0; i < e.n; i++) begin
          wait_ticks(16);
          @(negedge clk);
          got[i] = tx_line;
        end
        check(got == e.bits, {e.tag, " data bits"}, got, e.bits);
        wait_ticks(16);
        @(negedge clk);
        check(tx_line == 1'b1 && busy, {e.tag, " stop bit"}, {tx_line, busy}, 2'b11);
        seen = 1'b0;
        for (int k = 0; k < 200 && !seen; k++) begin
          @(negedge clk);
          if (done) seen = 1'b1;
        end
        check(seen && !busy, "R7 done with busy low", {seen, busy}, 2'b10);
        @(negedge clk);
        check(!done, "R7 done one cycle", done, 0);
        frames_seen++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_line && !busy && !done && in_ready, "R1 reset state",
          {tx_line, busy, done, in_ready}, 4'b1001);

    send(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    send(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    send(8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    send(8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    send(8'h13, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    send(8'h13, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
    send(8'hF1, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
    send(8'h00, 1'b1, 1'b1, 1'b1, 1'b1, "R5");

    // R6: parity controls flipped mid-frame
    send(8'h07, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    repeat (40) @(negedge clk);
    cfg_par_odd = 1'b1; cfg_par_en = 1'b0;

    // R9: baud ticks stopped mid-frame
    send(8'h6E, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    repeat (100) @(negedge clk);
    tick_en = 1'b0;
    @(negedge clk);
    held = tx_line;
    repeat (200) @(negedge clk);
    check(tx_line == held && busy, "R9 line held without ticks",
          {tx_line, busy}, {held, 1'b1});
    tick_en = 1'b1;

    // R8: sleep raised mid-frame
    send(8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    repeat (60) @(negedge clk);
    cfg_sleep = 1'b1;
    in_valid = 1'b1; in_data = 8'hC3;
    while (busy) @(negedge clk);
    for (int j = 0; j < 100; j++) begin
      @(negedge clk);
      if (in_ready || busy || !tx_line)
        check(1'b0, "R8 sleeping idle", {in_ready, busy, tx_line}, 3'b001);
    end
    check(!in_ready && !busy && tx_line, "R8 sleeping idle",
          {in_ready, busy, tx_line}, 3'b001);
    in_valid = 1'b0;
    cfg_sleep = 1'b0;
    send(8'h81, 1'b0, 1'b0, 1'b0, 1'b0, "R8");

    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(frames_seen == sent, "R7 frame count", frames_seen, sent);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule